// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This unit decides, for the descriptor a DMA channel is currently executing, whether three separate actions take effect: raising an interrupt, taking a branch, and holding the channel in a wait. Each action has a two-bit mode field in the command word. The four modes are never, always, fire on a match, and fire on a mismatch. The match is a masked compare of the channel's four device status bits against a compare value. Each action has its own select word, which holds the mask and the compare value. All three actions read the same status bits.

The channel sequencer pulses `eval_en` while the command word, the status and the three select words are valid. One cycle later the unit presents three single-cycle flags: interrupt fire, branch taken and wait hold. An interrupt that fires also sets a sticky pending output. That output stays high until software pulses `irq_clr`. Fetching descriptors and acting on a branch or a wait are left to the surrounding sequencer.

Top module: `dce_eval`

## Requirements
- R1: After reset, `irq_fire`, `br_taken`, `wait_hold` and `irq_pending` are all 0.
- R2: The condition of an action is true when (status AND mask) equals (value AND mask). Status is `chan_status[3:0]`. The mask is bits [19:16] of that action's select word and the value is bits [3:0]. All other bits of the select word are ignored.
- R3: Mode codes are 0 = never, 1 = fire if the condition is true, 2 = fire if the condition is false, 3 = always. The interrupt mode is `cmd_word[5:4]`, the branch mode is `cmd_word[3:2]` and the wait mode is `cmd_word[1:0]`. The other command bits are ignored.
- R4: Mode 0 never raises its flag, and mode 3 always raises it, whatever the condition.
- R5: Mode 1 raises its flag exactly when the condition is true. Mode 2 raises it exactly when the condition is false.
- R6: The interrupt uses `irq_sel`, the branch uses `br_sel` and the wait uses `wait_sel`. All three use the same status nibble.
- R7: The flags are registered. They show the decision in the cycle after a cycle with `eval_en` high, and they are 0 after any cycle with `eval_en` low.
- R8: `irq_pending` rises together with `irq_fire` and stays high until a cycle with `irq_clr` high. It is 0 after that cycle.
- R9: If an interrupt fires in the same cycle that `irq_clr` is high, the set wins and `irq_pending` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_en | input | 1 | Evaluate the current descriptor this cycle |
| cmd_word | input | CMD_W (16) | Command word carrying the three mode fields |
| chan_status | input | STS_W (32) | Channel status; bits [3:0] are the device status |
| irq_sel | input | SEL_W (32) | Interrupt mask/value select word |
| br_sel | input | SEL_W (32) | Branch mask/value select word |
| wait_sel | input | SEL_W (32) | Wait mask/value select word |
| irq_clr | input | 1 | Software clear of the pending interrupt |
| irq_fire | output | 1 | Interrupt decision pulse |
| br_taken | output | 1 | Branch decision pulse |
| wait_hold | output | 1 | Wait decision pulse |
| irq_pending | output | 1 | Sticky interrupt request |

## Verification
The two functions that can fall in the same cycle are an interrupt firing and a software clear of the pending bit. The sweep drives `irq_clr` together with `eval_en` using a parity pattern over status, mask and value. The bench therefore sees a clear arrive during firing, non-firing, never and always modes. After each evaluation the bench models the pending bit arithmetically, with a fire taking priority over a clear. It then compares that model, and the three flags, against the outputs one cycle later.

// File: rtl/dce_pkg.sv
package dce_pkg;

  localparam int NIB_W  = 4;
  localparam int MODE_W = 2;
  localparam int N_ACT  = 3;
  // action index; mode field sits at cmd_word[2*idx+1 : 2*idx]
  localparam int ACT_WAIT = 0;
  localparam int ACT_BR   = 1;
  localparam int ACT_IRQ  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_NEVER  = 2'd0,
    MODE_IFSET  = 2'd1,
    MODE_IFCLR  = 2'd2,
    MODE_ALWAYS = 2'd3
  } act_mode_e;

  function automatic logic masked_match(input logic [NIB_W-1:0] stat,
                                        input logic [NIB_W-1:0] mask,
                                        input logic [NIB_W-1:0] val);
    return (stat & mask) == (val & mask);
  endfunction

  function automatic logic mode_fires(input act_mode_e mode, input logic hit);
    case (mode)
      MODE_NEVER:  return 1'b0;
      MODE_IFSET:  return hit;
      MODE_IFCLR:  return ~hit;
      default:     return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/dce_decider.sv
module dce_decider
  import dce_pkg::*;
#(
  parameter int SEL_W    = 32,
  parameter int MASK_LSB = 16,
  parameter int VAL_LSB  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 eval_en,
  input  logic [MODE_W-1:0]    mode,
  input  logic [NIB_W-1:0]     stat,
  input  logic [SEL_W-1:0]     sel,
  output logic                 hit,
  output logic                 fire_now,
  output logic                 fire_q
);

  logic [NIB_W-1:0] mask_f;
  logic [NIB_W-1:0] val_f;
  logic             unused_sel;

  assign mask_f     = sel[MASK_LSB +: NIB_W];
  assign val_f      = sel[VAL_LSB  +: NIB_W];
  assign unused_sel = ^sel;

  assign hit      = masked_match(stat, mask_f, val_f);
  assign fire_now = eval_en & mode_fires(act_mode_e'(mode), hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_now;
  end

endmodule

// File: rtl/dce_sticky.sv
module dce_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

endmodule

// File: rtl/dce_eval.sv
module dce_eval
  import dce_pkg::*;
#(
  parameter int SEL_W    = 32,
  parameter int MASK_LSB = 16,
  parameter int VAL_LSB  = 0,
  parameter int STS_W    = 32,
  parameter int CMD_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_en,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic [STS_W-1:0] chan_status,
  input  logic [SEL_W-1:0] irq_sel,
  input  logic [SEL_W-1:0] br_sel,
  input  logic [SEL_W-1:0] wait_sel,
  input  logic             irq_clr,
  output logic             irq_fire,
  output logic             br_taken,
  output logic             wait_hold,
  output logic             irq_pending
);

  localparam int MODES_W = N_ACT * MODE_W;

  logic [SEL_W-1:0]   sel_arr [N_ACT];
  logic [NIB_W-1:0]   dev_nib;
  logic [N_ACT-1:0]   cond_hit;
  logic [N_ACT-1:0]   fire_now;
  logic [N_ACT-1:0]   fire_q;
  logic [MODES_W-1:0] act_modes;
  logic               unused_bits;

  assign sel_arr[ACT_WAIT] = wait_sel;
  assign sel_arr[ACT_BR]   = br_sel;
  assign sel_arr[ACT_IRQ]  = irq_sel;

  assign dev_nib     = chan_status[NIB_W-1:0];
  assign act_modes   = cmd_word[MODES_W-1:0];
  assign unused_bits = ^{cmd_word, chan_status};

  for (genvar g = 0; g < N_ACT; g++) begin : g_act
    dce_decider #(
      .SEL_W    (SEL_W),
      .MASK_LSB (MASK_LSB),
      .VAL_LSB  (VAL_LSB)
    ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .eval_en  (eval_en),
      .mode     (act_modes[g*MODE_W +: MODE_W]),
      .stat     (dev_nib),
      .sel      (sel_arr[g]),
      .hit      (cond_hit[g]),
      .fire_now (fire_now[g]),
      .fire_q   (fire_q[g])
    );
  end

  dce_sticky u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (fire_now[ACT_IRQ]),
    .clr_i (irq_clr),
    .q     (irq_pending)
  );

  assign irq_fire  = fire_q[ACT_IRQ];
  assign br_taken  = fire_q[ACT_BR];
  assign wait_hold = fire_q[ACT_WAIT];

endmodule

// File: rtl/dce_eval_chk.sv
module dce_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eval_en,
  input logic       irq_clr,
  input logic [5:0] modes,
  input logic [2:0] cond_hit,
  input logic       irq_fire,
  input logic       br_taken,
  input logic       wait_hold,
  input logic       irq_pending
);

  // R7: no evaluation, no flags next cycle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_en |=> (!irq_fire && !br_taken && !wait_hold));

  // R4: never / always
  a_r4_irq_never: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && modes[5:4] == 2'd0) |=> !irq_fire);
  a_r4_br_always: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && modes[3:2] == 2'd3) |=> br_taken);

  // R5: conditional modes follow the compare
  a_r5_wait_ifset: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && modes[1:0] == 2'd1) |=> (wait_hold == $past(cond_hit[0])));
  a_r5_irq_ifclr: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && modes[5:4] == 2'd2) |=> (irq_fire == !$past(cond_hit[2])));

  // R8: pending holds, and a lone clear drops it
  a_r8_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_clr) |=> irq_pending);
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !eval_en) |=> !irq_pending);

  // R9: a firing interrupt always leaves pending set, clear or not
  a_r9_fire_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fire |-> irq_pending);

endmodule

bind dce_eval dce_eval_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eval_en     (eval_en),
  .irq_clr     (irq_clr),
  .modes       (act_modes),
  .cond_hit    (cond_hit),
  .irq_fire    (irq_fire),
  .br_taken    (br_taken),
  .wait_hold   (wait_hold),
  .irq_pending (irq_pending)
);

// File: tb/dce_eval_test.sv
module dce_eval_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_en = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [31:0] chan_status = '0;
  logic [31:0] irq_sel = '0;
  logic [31:0] br_sel = '0;
  logic [31:0] wait_sel = '0;
  logic        irq_clr = 1'b0;
  logic        irq_fire, br_taken, wait_hold, irq_pending;

  int checks = 0;
  int errors = 0;
  bit model_pend = 1'b0;

  always #4 clk = ~clk;

  dce_eval uut (
    .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .cmd_word(cmd_word),
    .chan_status(chan_status), .irq_sel(irq_sel), .br_sel(br_sel),
    .wait_sel(wait_sel), .irq_clr(irq_clr), .irq_fire(irq_fire),
    .br_taken(br_taken), .wait_hold(wait_hold), .irq_pending(irq_pending)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // expected decision, written independently of the design
  function automatic bit want(input int mode, input int st, input int mk, input int vl);
    bit c;
    c = (((st ^ vl) & mk) & 4'hF) == 0;
    case (mode)
      0: return 1'b0;
      1: return c;
      2: return !c;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag(input int mode);
    return (mode == 1 || mode == 2) ? "R5 R2 R3 R6" : "R4 R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq_fire", irq_fire, 1'b0);
    check("R1 br_taken", br_taken, 1'b0);
    check("R1 wait_hold", wait_hold, 1'b0);
    check("R1 irq_pending", irq_pending, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 4; m++) begin
      for (int st = 0; st < 16; st++) begin
        for (int mk = 0; mk < 16; mk++) begin
          for (int vl = 0; vl < 16; vl++) begin
            int  mi, mb, mw, wmk, wvl;
            bit  ei, eb, ew, clr;
            mi  = m;
            mb  = (m + 1) % 4;
            mw  = (m + 2) % 4;
            wmk = (mk ^ vl) & 15;
            wvl = (~vl) & 15;
            clr = mk[0] ^ vl[1] ^ st[2];
            // junk outside the mode fields and the mask/value nibbles (R2, R3)
            cmd_word    = {10'h2D7, mi[1:0], mb[1:0], mw[1:0]};
            chan_status = {28'hC3A5F1E, st[3:0]};
            irq_sel     = {12'hABC, mk[3:0], 12'h5A5, vl[3:0]};
            br_sel      = {12'h123, vl[3:0], 12'hFFF, mk[3:0]};
            wait_sel    = {12'h777, wmk[3:0], 12'h0C0, wvl[3:0]};
            eval_en     = 1'b1;
            irq_clr     = clr;
            ei = want(mi, st, mk, vl);
            eb = want(mb, st, vl, mk);
            ew = want(mw, st, wmk, wvl);
            @(posedge clk);
            @(negedge clk);
            check({"irq ", tag(mi)}, irq_fire, ei);
            check({"br ", tag(mb)}, br_taken, eb);
            check({"wait ", tag(mw)}, wait_hold, ew);
            model_pend = ei ? 1'b1 : (clr ? 1'b0 : model_pend);
            check((ei && clr) ? "R9 pending" : "R8 pending", irq_pending, model_pend);
            // idle cycle: flags drop, pending holds
            eval_en = 1'b0;
            irq_clr = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check("R7 irq idle", irq_fire, 1'b0);
            check("R7 br idle", br_taken, 1'b0);
            check("R7 wait idle", wait_hold, 1'b0);
            check("R8 pending hold", irq_pending, model_pend);
          end
        end
      end
    end

    // R8: a lone clear drops a set pending bit
    cmd_word = 16'h0030;
    eval_en  = 1'b1;
    @(posedge clk); @(negedge clk);
    eval_en = 1'b0;
    check("R8 set by always", irq_pending, 1'b1);
    irq_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    irq_clr = 1'b0;
    check("R8 cleared", irq_pending, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule